// File: doc/BRIEF.md
# Sector Erase Batch Window

This block sits behind the command decoder of a flash device and gathers sector erase requests into one erase batch. The first sector erase command opens an acceptance window and marks its sector in a selection mask. Each later sector erase command that arrives while the window is open adds its sector and restarts the window at full length. When the window runs out, the block raises its status bit, sends one start pulse to the erase sequencer and holds the mask steady until the sequencer reports completion.

The window is measured in periods of a one-microsecond tick input. The length is a parameter: the device value is 50 ticks, and a simulation can use a shorter one. A chip erase command does not use the window. It selects every sector and starts at once. While the erase runs, the block ignores all commands except erase suspend. It forwards that command as a one-cycle request.

Top module: `sector_erase_batcher`

## Requirements
- R1: After reset, sel_mask is all zeros and erase_busy, erase_start and suspend_req are 0.
- R2: A sector erase pulse while erase_busy is 0, with cmd_sector below NUM_SECTORS, sets bit cmd_sector of sel_mask from the next cycle on and leaves erase_busy at 0.
- R3: Each accepted sector erase reloads the window. The window closes on the WINDOW_TICKS-th tick_us pulse that comes after the last accepted sector erase. If a sector erase and a tick arrive in the same cycle, the sector erase wins and the window restarts.
- R4: When the window closes, erase_busy becomes 1 and erase_start is 1 for exactly that one cycle. This happens in the cycle after the closing tick.
- R5: While erase_busy is 1, sector erase, chip erase and other command pulses do not change sel_mask or erase_busy, and they produce no erase_start.
- R6: An erase suspend pulse while erase_busy is 1 gives suspend_req = 1 for one cycle in the next cycle. While erase_busy is 0, erase suspend gives no suspend_req and has no other effect.
- R7: A chip erase pulse while no window is open and erase_busy is 0 sets sel_mask to all ones and erase_busy to 1 in the next cycle, together with one erase_start pulse.
- R8: erase_done while erase_busy is 1 clears sel_mask and erase_busy in the next cycle. erase_done has no effect at other times.
- R9: While the window is open, chip erase, erase suspend, other command pulses and sector numbers at or above NUM_SECTORS do not change the mask. They do not restart the window or shorten it.
- R10: A sector erase command that arrives after the window has closed is dropped. Its sector bit stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle pulse once per microsecond |
| cmd_sector_erase | input | 1 | Decoded sector erase command pulse |
| cmd_chip_erase | input | 1 | Decoded chip erase command pulse |
| cmd_suspend | input | 1 | Decoded erase suspend command pulse |
| cmd_other | input | 1 | Any other decoded command pulse |
| cmd_sector | input | SEC_W | Sector number for the sector erase command |
| erase_done | input | 1 | Erase sequencer reports completion |
| sel_mask | output | NUM_SECTORS | Sectors selected for the batch |
| erase_start | output | 1 | One-cycle pulse that starts the erase |
| erase_busy | output | 1 | Status bit: 0 while commands are accepted, 1 once the erase has begun |
| suspend_req | output | 1 | One-cycle forwarded erase suspend request |

## Verification
A wrong window count shows up as an erase_start pulse in the wrong cycle. The error is visible on the first batch, one cycle after the expected closing tick. A lost reload shows up only when a sector command retriggers the window, and it makes erase_start come early. A state that fails to lock, or a mask update on a late command, shows up as a sel_mask change in the cycle after the stray command. A missed clear on completion shows up in the cycle after erase_done. The bench compares every port on every cycle against its own model, so each of these faults surfaces within one cycle of its cause.

// File: rtl/sector_erase_batcher.sv
module sector_erase_batcher #(
  parameter int NUM_SECTORS  = 16,
  parameter int WINDOW_TICKS = 50,
  parameter int SEC_W        = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_us,
  input  logic                   cmd_sector_erase,
  input  logic                   cmd_chip_erase,
  input  logic                   cmd_suspend,
  input  logic                   cmd_other,
  input  logic [SEC_W-1:0]       cmd_sector,
  input  logic                   erase_done,
  output logic [NUM_SECTORS-1:0] sel_mask,
  output logic                   erase_start,
  output logic                   erase_busy,
  output logic                   suspend_req
);
  localparam int CNT_W = $clog2(WINDOW_TICKS + 1);
  localparam bit FULL_RANGE = ((1 << SEC_W) == NUM_SECTORS);

  typedef enum logic [1:0] {ST_IDLE, ST_WINDOW, ST_ERASE} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic              sec_ok, take_sec, last_tick;

  assign sec_ok    = FULL_RANGE ? 1'b1 : (cmd_sector < SEC_W'(NUM_SECTORS));
  assign take_sec  = cmd_sector_erase && sec_ok && (st != ST_ERASE);
  assign last_tick = (st == ST_WINDOW) && tick_us && (cnt == CNT_W'(1));
  assign erase_busy = (st == ST_ERASE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      sel_mask    <= '0;
      erase_start <= 1'b0;
      suspend_req <= 1'b0;
    end else begin
      erase_start <= 1'b0;
      suspend_req <= 1'b0;
      if (take_sec) begin
        st       <= ST_WINDOW;
        cnt      <= CNT_W'(WINDOW_TICKS);
        sel_mask <= sel_mask | (NUM_SECTORS'(1) << cmd_sector);
      end else begin
        case (st)
          ST_IDLE: if (cmd_chip_erase) begin
            st          <= ST_ERASE;
            sel_mask    <= '1;
            erase_start <= 1'b1;
          end
          ST_WINDOW: if (last_tick) begin
            st          <= ST_ERASE;
            erase_start <= 1'b1;
          end else if (tick_us) begin
            cnt <= cnt - CNT_W'(1);
          end
          default: if (erase_done) begin
            st       <= ST_IDLE;
            sel_mask <= '0;
          end else if (cmd_suspend) begin
            suspend_req <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

module sector_erase_batcher_chk #(
  parameter int NUM_SECTORS = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   erase_done,
  input logic [NUM_SECTORS-1:0] sel_mask,
  input logic                   erase_start,
  input logic                   erase_busy,
  input logic                   suspend_req
);
  p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);
  p_start_with_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> erase_busy);
  p_busy_rise_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_busy) |-> erase_start);
  p_mask_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_busy && !erase_done) |=> $stable(sel_mask));
  p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_busy && erase_done) |=> (sel_mask == '0 && !erase_busy));
  p_suspend_when_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_req |-> erase_busy);
  p_busy_has_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    erase_busy |-> (sel_mask != '0));
endmodule

bind sector_erase_batcher sector_erase_batcher_chk #(.NUM_SECTORS(NUM_SECTORS)) u_chk (
  .clk(clk), .rst_n(rst_n), .erase_done(erase_done), .sel_mask(sel_mask),
  .erase_start(erase_start), .erase_busy(erase_busy), .suspend_req(suspend_req)
);

// File: tb/sector_erase_batcher_test.sv
module sector_erase_batcher_test;
  localparam int NS = 16;
  localparam int WT = 5;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 0, c_sec = 0, c_chip = 0, c_susp = 0, c_oth = 0, done = 0;
  logic [SW-1:0] c_idx = '0;
  logic [NS-1:0] sel_mask;
  logic erase_start, erase_busy, suspend_req;

  int errors = 0, checks = 0, cyc = 0;

  // model state: 0 idle, 1 window, 2 erase
  int m_st = 0, m_cnt = 0;
  logic [NS-1:0] m_mask = '0;
  logic m_start = 0, m_susp = 0;

  always #5 clk = ~clk;

  sector_erase_batcher #(.NUM_SECTORS(NS), .WINDOW_TICKS(WT)) uut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .cmd_sector_erase(c_sec),
    .cmd_chip_erase(c_chip), .cmd_suspend(c_susp), .cmd_other(c_oth),
    .cmd_sector(c_idx), .erase_done(done), .sel_mask(sel_mask),
    .erase_start(erase_start), .erase_busy(erase_busy), .suspend_req(suspend_req));

  task automatic chk(input bit ok, input string tag, input logic [NS-1:0] act, input logic [NS-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(sel_mask == m_mask, {tag, " mask"}, sel_mask, m_mask);
    chk(erase_busy == (m_st == 2), {tag, " busy"}, NS'(erase_busy), NS'(m_st == 2));
    chk(erase_start == m_start, {tag, " start"}, NS'(erase_start), NS'(m_start));
    chk(suspend_req == m_susp, {tag, " suspend"}, NS'(suspend_req), NS'(m_susp));
  endtask

  function automatic void model_step();
    m_start = 0;
    m_susp = 0;
    if (c_sec && m_st != 2) begin
      m_st = 1; m_cnt = WT; m_mask[c_idx] = 1'b1;
    end else if (m_st == 0) begin
      if (c_chip) begin m_st = 2; m_mask = '1; m_start = 1; end
    end else if (m_st == 1) begin
      if (tick_us) begin
        m_cnt--;
        if (m_cnt == 0) begin m_st = 2; m_start = 1; end
      end
    end else begin
      if (done) begin m_st = 0; m_mask = '0; end
      else if (c_susp) m_susp = 1;
    end
  endfunction

  task automatic cycle(input bit t, input bit s, input bit ch, input bit su,
                       input bit o, input int idx, input bit d, input string tag);
    @(negedge clk);
    tick_us = t; c_sec = s; c_chip = ch; c_susp = su; c_oth = o;
    c_idx = SW'(idx); done = d;
    model_step();
    @(posedge clk);
    cyc++;
    @(negedge clk);
    compare(tag);
    tick_us = 0; c_sec = 0; c_chip = 0; c_susp = 0; c_oth = 0; done = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 reset");
    rst_n = 1;
    idle(1, "R1 after reset");

    // R2 accept, R3 retrigger on final tick, R4 close
    cycle(0, 1, 0, 0, 0, 3, 0, "R2 first sector");
    for (int i = 0; i < WT - 1; i++) cycle(1, 0, 0, 0, 0, 0, 0, "R3 counting");
    cycle(1, 1, 0, 0, 0, 9, 0, "R3 retrigger wins over tick");
    cycle(0, 0, 1, 1, 1, 0, 0, "R9 chip/suspend/other in window");
    for (int i = 0; i < WT - 1; i++) cycle(1, 0, 0, 0, 0, 0, 0, "R3 full reload");
    cycle(1, 0, 0, 0, 0, 0, 0, "R4 window closes");
    idle(1, "R4 start single pulse");
    cycle(0, 1, 0, 0, 0, 12, 0, "R10 late sector dropped");
    cycle(0, 0, 1, 0, 0, 0, 0, "R5 chip erase ignored when busy");
    cycle(0, 0, 0, 0, 1, 0, 0, "R5 other ignored when busy");
    cycle(0, 0, 0, 1, 0, 0, 0, "R6 suspend forwarded");
    idle(1, "R6 suspend one cycle");
    cycle(0, 0, 0, 0, 0, 0, 1, "R8 done clears");
    cycle(0, 0, 0, 1, 0, 0, 1, "R6 suspend/R8 done ignored when idle");
    cycle(0, 0, 1, 0, 0, 0, 0, "R7 chip erase");
    cycle(0, 0, 0, 0, 0, 0, 1, "R8 done after chip erase");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      bit t = ($urandom_range(0, 2) == 0);
      bit s = 0, ch = 0, su = 0, o = 0, d = 0;
      if (r < 12) s = 1;
      else if (r < 15) ch = 1;
      else if (r < 20) su = 1;
      else if (r < 26) o = 1;
      d = (m_st == 2) ? ($urandom_range(0, 14) == 0) : ($urandom_range(0, 30) == 0);
      cycle(t, s, ch, su, o, int'($urandom_range(0, NS - 1)), d, "R3/R5 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule